// File: doc/BRIEF.md
# Burst Read Output Sequencer

This block is the memory-side model of a double-data-rate read data path. Each clock it takes one decoded command: a no-operation, a column read, a burst stop, or a write. A read is carried through a delay line for the CAS latency and then drives the data-bus output enable, the strobe enable and the index and column of the two beats sent on the rising and falling halves of each clock. It never holds array data. It only reports which column beat is on the bus in each half cycle.

A later read cuts off the beats that remain from the earlier one. A burst stop floats the bus exactly one CAS latency after it is issued. A burst stop that arrives while a write is running is refused: it raises a one-cycle illegal-command flag and has no other effect.

Inside, a finite-state machine has three states. `ST_IDLE` means the bus is floating. `ST_LEAD` sends the first beat pair of a burst. `ST_TRAIL` sends the pairs that follow. A read arriving from the delay line moves any state to `ST_LEAD` (restart). A stop arriving moves any state to `ST_IDLE` (float). If neither arrives, `ST_LEAD` advances to `ST_TRAIL` (advance). `ST_TRAIL` steps through its pairs and returns to `ST_IDLE` after the last one (drain).

Top module: `burst_read_seq`

## Requirements
- R1: Command codes are 2'b00 no-op, 2'b01 read, 2'b10 burst stop and 2'b11 write. A read sampled at clock edge n sets `dq_oe` high after edges n+3 and n+4 (CAS latency 3, burst length 4, two beats per clock). It is low again after edge n+5 unless another read or stop applies.
- R2: In the k-th data clock of a burst (k = 0, 1), `rise_idx` is 2k and `fall_idx` is 2k+1. The index starts again at 0 for every read.
- R3: The beat column keeps every bit of the read column above bit 1. Its two low bits are the read column's low two bits plus the beat index, modulo 4 (sequential wrap inside an aligned group of four).
- R4: `dqs_oe` is high in every data clock. It is also high for one preamble clock just before the first data clock of a burst that starts from a floating bus.
- R5: A read sampled one or more clocks after an earlier read replaces the earlier burst's remaining beats. From its own latency point it delivers its full burst, starting at index 0.
- R6: A burst stop sampled at edge n while a read is in flight lets through the beats due before edge n+3. From edge n+3 on, `dq_oe` and `dqs_oe` are low.
- R7: A burst stop acts the same whatever value `cmd_bank` carries. `burst_bank` keeps reporting the read's bank for the beats still sent.
- R8: A burst stop sampled when no read is queued and no burst is on the bus changes no output.
- R9: A write sampled at edge w opens a write window for edges w+1 to w+3. A burst stop sampled inside that window sets `illegal_cmd` high for the clock after that edge only. It does not stop a running read. A stop at edge w+4 is legal.
- R10: During reset, and whenever no burst is on the bus, `dq_oe`, `illegal_cmd`, the indices, the columns and `burst_bank` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd | input | 2 | Decoded command for this clock |
| cmd_bank | input | 2 | Bank field of the command (ignored for a stop) |
| cmd_col | input | 9 | Column field of the command |
| dq_oe | output | 1 | Data bus driven |
| dqs_oe | output | 1 | Strobe driven, including the preamble clock |
| rise_idx | output | 2 | Beat index on the rising half |
| fall_idx | output | 2 | Beat index on the falling half |
| rise_col | output | 9 | Column of the rising-half beat |
| fall_col | output | 9 | Column of the falling-half beat |
| burst_bank | output | 2 | Bank of the burst on the bus |
| illegal_cmd | output | 1 | One-clock flag for a stop refused during a write |

## Verification
A restart and a float can meet in one clock when a read is issued just after a stop, or a stop just after a read. In that case the delay line hands the state machine a stop and then a read on neighbouring edges, while the preamble logic looks ahead at the read. The bench provokes this with read-stop-read patterns. It also sends a stop inside a write window while a read is in flight. It judges each clock against a timeline of expected beats, which it builds from the commands alone. In that timeline a later read overwrites earlier slots, a stop clears the slots after its latency point, and a refused stop only posts an illegal flag.

// File: rtl/brs_pkg.sv
package brs_pkg;

    typedef enum logic [1:0] {
        CMD_NOP   = 2'b00,
        CMD_READ  = 2'b01,
        CMD_STOP  = 2'b10,
        CMD_WRITE = 2'b11
    } cmd_e;

    typedef enum logic [1:0] {
        EV_NONE = 2'b00,
        EV_READ = 2'b01,
        EV_STOP = 2'b10
    } ev_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_LEAD  = 2'b01,
        ST_TRAIL = 2'b10
    } burst_state_e;

endpackage

// File: rtl/brs_cmd_pipe.sv
module brs_cmd_pipe
    import brs_pkg::*;
#(
    parameter int CL     = 3,
    parameter int COL_W  = 9,
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ev_e               in_kind,
    input  logic [BANK_W-1:0] in_bank,
    input  logic [COL_W-1:0]  in_col,
    output ev_e               pre_kind,
    output ev_e               head_kind,
    output logic [BANK_W-1:0] head_bank,
    output logic [COL_W-1:0]  head_col,
    output logic [CL-1:0]     read_map
);

    ev_e               kind_q [CL];
    logic [BANK_W-1:0] bank_q [CL];
    logic [COL_W-1:0]  col_q  [CL];

    // Delay line: stage 0 takes the new event, each later stage the one before.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < CL; s++) begin
                kind_q[s] <= EV_NONE;
                bank_q[s] <= '0;
                col_q[s]  <= '0;
            end
        end else begin
            kind_q[0] <= in_kind;
            bank_q[0] <= in_bank;
            col_q[0]  <= in_col;
            for (int s = 1; s < CL; s++) begin
                kind_q[s] <= kind_q[s-1];
                bank_q[s] <= bank_q[s-1];
                col_q[s]  <= col_q[s-1];
            end
        end
    end

    for (genvar s = 0; s < CL; s++) begin : g_map
        assign read_map[s] = (kind_q[s] == EV_READ);
    end

    assign pre_kind  = kind_q[CL-2];
    assign head_kind = kind_q[CL-1];
    assign head_bank = bank_q[CL-1];
    assign head_col  = col_q[CL-1];

endmodule

// File: rtl/brs_write_guard.sv
module brs_write_guard #(
    parameter int WR_WIN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_write,
    input  logic cmd_stop,
    output logic stop_blocked,
    output logic illegal_cmd
);

    localparam int CNT_W = $clog2(WR_WIN + 1);

    logic [CNT_W-1:0] win_q;
    logic             flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            if (cmd_write) begin
                win_q <= CNT_W'(WR_WIN);
            end else if (win_q != '0) begin
                win_q <= win_q - 1'b1;
            end
            flag_q <= cmd_stop && (win_q != '0);
        end
    end

    assign stop_blocked = cmd_stop && (win_q != '0);
    assign illegal_cmd  = flag_q;

    a_r9_flag_from_stop : assert property (@(posedge clk) disable iff (!rst_n)
        illegal_cmd |-> $past(cmd_stop));

endmodule

// File: rtl/brs_burst_fsm.sv
module brs_burst_fsm
    import brs_pkg::*;
#(
    parameter int BL     = 4,
    parameter int COL_W  = 9,
    parameter int BANK_W = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  ev_e                   head_kind,
    input  logic [BANK_W-1:0]     head_bank,
    input  logic [COL_W-1:0]      head_col,
    input  ev_e                   pre_kind,
    output logic                  dq_oe,
    output logic                  dqs_oe,
    output logic [$clog2(BL)-1:0] rise_idx,
    output logic [$clog2(BL)-1:0] fall_idx,
    output logic [COL_W-1:0]      rise_col,
    output logic [COL_W-1:0]      fall_col,
    output logic [BANK_W-1:0]     burst_bank
);

    localparam int PAIRS  = BL / 2;
    localparam int PAIR_W = $clog2(PAIRS);
    localparam int IDX_W  = PAIR_W + 1;

    burst_state_e      state_q, state_nxt;
    logic [PAIR_W-1:0] pair_q, pair_nxt;
    logic [COL_W-1:0]  col_q, col_nxt;
    logic [BANK_W-1:0] bank_q, bank_nxt;
    logic              pre_q;

    // Next-state logic: restart, float, advance, drain.
    always_comb begin
        state_nxt = state_q;
        pair_nxt  = pair_q;
        col_nxt   = col_q;
        bank_nxt  = bank_q;
        unique case (state_q)
            ST_IDLE: begin
                pair_nxt = '0;
            end
            ST_LEAD: begin
                if (PAIRS > 1) begin
                    state_nxt = ST_TRAIL;
                    pair_nxt  = PAIR_W'(1);
                end else begin
                    state_nxt = ST_IDLE;
                    pair_nxt  = '0;
                end
            end
            ST_TRAIL: begin
                if (pair_q == PAIR_W'(PAIRS - 1)) begin
                    state_nxt = ST_IDLE;
                    pair_nxt  = '0;
                end else begin
                    pair_nxt = pair_q + 1'b1;
                end
            end
            default: begin
                state_nxt = ST_IDLE;
                pair_nxt  = '0;
            end
        endcase
        if (head_kind == EV_READ) begin
            state_nxt = ST_LEAD;
            pair_nxt  = '0;
            col_nxt   = head_col;
            bank_nxt  = head_bank;
        end else if (head_kind == EV_STOP) begin
            state_nxt = ST_IDLE;
            pair_nxt  = '0;
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pair_q  <= '0;
            col_q   <= '0;
            bank_q  <= '0;
            pre_q   <= 1'b0;
        end else begin
            state_q <= state_nxt;
            pair_q  <= pair_nxt;
            col_q   <= col_nxt;
            bank_q  <= bank_nxt;
            pre_q   <= (pre_kind == EV_READ) && (state_nxt == ST_IDLE);
        end
    end

    logic [IDX_W-1:0] rise_lo, fall_lo;

    // Output logic.
    always_comb begin
        dq_oe      = 1'b0;
        dqs_oe     = pre_q;
        rise_idx   = '0;
        fall_idx   = '0;
        rise_lo    = '0;
        fall_lo    = '0;
        rise_col   = '0;
        fall_col   = '0;
        burst_bank = '0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_LEAD, ST_TRAIL: begin
                dq_oe      = 1'b1;
                dqs_oe     = 1'b1;
                rise_idx   = {pair_q, 1'b0};
                fall_idx   = {pair_q, 1'b1};
                rise_lo    = col_q[IDX_W-1:0] + {pair_q, 1'b0};
                fall_lo    = col_q[IDX_W-1:0] + {pair_q, 1'b1};
                rise_col   = {col_q[COL_W-1:IDX_W], rise_lo};
                fall_col   = {col_q[COL_W-1:IDX_W], fall_lo};
                burst_bank = bank_q;
            end
            default: begin
            end
        endcase
    end

    a_r5_read_restarts : assert property (@(posedge clk) disable iff (!rst_n)
        ($past(head_kind) == EV_READ) |-> (dq_oe && rise_idx == '0));

    a_r6_stop_floats : assert property (@(posedge clk) disable iff (!rst_n)
        ($past(head_kind) == EV_STOP) |-> !dq_oe);

    a_r4_preamble_leads : assert property (@(posedge clk) disable iff (!rst_n)
        (dqs_oe && !dq_oe) |=> (dq_oe && rise_idx == '0));

    a_r2_trail_after_burst : assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TRAIL) |-> ($past(state_q) != ST_IDLE));

endmodule

// File: rtl/burst_read_seq.sv
module burst_read_seq
    import brs_pkg::*;
#(
    parameter int CL     = 3,
    parameter int BL     = 4,
    parameter int COL_W  = 9,
    parameter int BANK_W = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            cmd,
    input  logic [BANK_W-1:0]     cmd_bank,
    input  logic [COL_W-1:0]      cmd_col,
    output logic                  dq_oe,
    output logic                  dqs_oe,
    output logic [$clog2(BL)-1:0] rise_idx,
    output logic [$clog2(BL)-1:0] fall_idx,
    output logic [COL_W-1:0]      rise_col,
    output logic [COL_W-1:0]      fall_col,
    output logic [BANK_W-1:0]     burst_bank,
    output logic                  illegal_cmd
);

    localparam int IDX_W  = $clog2(BL);
    localparam int WR_WIN = 1 + BL / 2;

    cmd_e              cmd_dec;
    ev_e               in_kind;
    ev_e               pre_kind, head_kind;
    logic [BANK_W-1:0] head_bank;
    logic [COL_W-1:0]  head_col;
    logic [CL-1:0]     read_map;
    logic              stop_blocked;
    logic              in_flight;

    assign cmd_dec   = cmd_e'(cmd);
    assign in_flight = (|read_map) || dq_oe;

    always_comb begin
        unique case (cmd_dec)
            CMD_READ: in_kind = EV_READ;
            CMD_STOP: in_kind = (!stop_blocked && in_flight) ? EV_STOP : EV_NONE;
            default:  in_kind = EV_NONE;
        endcase
    end

    brs_write_guard #(.WR_WIN(WR_WIN)) u_guard (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_write    (cmd_dec == CMD_WRITE),
        .cmd_stop     (cmd_dec == CMD_STOP),
        .stop_blocked (stop_blocked),
        .illegal_cmd  (illegal_cmd)
    );

    brs_cmd_pipe #(.CL(CL), .COL_W(COL_W), .BANK_W(BANK_W)) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_kind   (in_kind),
        .in_bank   (cmd_bank),
        .in_col    (cmd_col),
        .pre_kind  (pre_kind),
        .head_kind (head_kind),
        .head_bank (head_bank),
        .head_col  (head_col),
        .read_map  (read_map)
    );

    brs_burst_fsm #(.BL(BL), .COL_W(COL_W), .BANK_W(BANK_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .head_kind  (head_kind),
        .head_bank  (head_bank),
        .head_col   (head_col),
        .pre_kind   (pre_kind),
        .dq_oe      (dq_oe),
        .dqs_oe     (dqs_oe),
        .rise_idx   (rise_idx),
        .fall_idx   (fall_idx),
        .rise_col   (rise_col),
        .fall_col   (fall_col),
        .burst_bank (burst_bank)
    );

    a_r9_refused_not_queued : assert property (@(posedge clk) disable iff (!rst_n)
        illegal_cmd |-> ($past(in_kind) != EV_STOP));

    a_r1_oe_rise_from_read : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq_oe) |-> ($past(head_kind) == EV_READ));

    a_r3_same_group : assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (rise_col[COL_W-1:IDX_W] == fall_col[COL_W-1:IDX_W]));

endmodule

// File: tb/burst_read_seq_tb_top.sv
`timescale 1ns/1ps
module burst_read_seq_tb_top;

    localparam int CL    = 3;
    localparam int DEPTH = 2048;
    localparam logic [1:0] C_NOP = 2'b00, C_READ = 2'b01, C_STOP = 2'b10, C_WRITE = 2'b11;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cmd = C_NOP;
    logic [1:0] cmd_bank = '0;
    logic [8:0] cmd_col = '0;
    logic       dq_oe, dqs_oe, illegal_cmd;
    logic [1:0] rise_idx, fall_idx, burst_bank;
    logic [8:0] rise_col, fall_col;

    burst_read_seq dut_i (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .cmd_bank(cmd_bank), .cmd_col(cmd_col),
        .dq_oe(dq_oe), .dqs_oe(dqs_oe), .rise_idx(rise_idx), .fall_idx(fall_idx),
        .rise_col(rise_col), .fall_col(fall_col), .burst_bank(burst_bank),
        .illegal_cmd(illegal_cmd)
    );

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0, failures = 0;
    bit mon_on = 1'b0, done = 1'b0;
    int last_wr = -100;

    // Scoreboard timeline, indexed by the clock count at which it is observed.
    bit         x_oe    [DEPTH];
    bit         x_first [DEPTH];
    int         x_pair  [DEPTH];
    logic [8:0] x_base  [DEPTH];
    logic [1:0] x_bank  [DEPTH];
    bit         x_ill   [DEPTH];
    string      x_tag   [DEPTH];

    function automatic int colf(input logic [8:0] base, input int idx);
        logic [1:0] lo;
        lo = base[1:0] + 2'(idx);
        return int'({base[8:2], lo});
    endfunction

    task automatic check(input string tag, input string what, input int act, input int expv);
        checks++;
        if (act != expv) begin
            failures++;
            $display("FAIL %s %s at clock %0d: actual=%0d expected=%0d", tag, what, cyc, act, expv);
        end
    endtask

    // Driver: applies a command and pushes its expected effect into the timeline.
    task automatic issue(input logic [1:0] c, input logic [1:0] b, input logic [8:0] col,
                         input string tag);
        int e;
        @(negedge clk);
        cmd = c; cmd_bank = b; cmd_col = col;
        e = cyc + 1;
        if (c == C_READ) begin
            for (int p = 0; p < 2; p++) begin
                x_oe[e+CL+p]    = 1'b1;
                x_first[e+CL+p] = (p == 0);
                x_pair[e+CL+p]  = p;
                x_base[e+CL+p]  = col;
                x_bank[e+CL+p]  = b;
                x_tag[e+CL+p]   = tag;
            end
        end else if (c == C_STOP) begin
            if (e - last_wr >= 1 && e - last_wr <= 3) begin
                x_ill[e] = 1'b1;
            end else begin
                for (int k = e + CL; k < e + CL + 4; k++) begin
                    x_oe[k]    = 1'b0;
                    x_first[k] = 1'b0;
                    x_tag[k]   = tag;
                end
            end
        end else if (c == C_WRITE) begin
            last_wr = e;
        end
    endtask

    task automatic nops(input int n);
        for (int i = 0; i < n; i++) issue(C_NOP, 2'b00, 9'h000, "");
    endtask

    // Monitor: compares outputs with the timeline every clock, away from the rising edge.
    always @(negedge clk) begin : monitor
        int c, ri, fi, rc, fc, bk;
        bit eo, ed;
        string tg;
        if (mon_on && !done) begin
            c  = cyc;
            eo = x_oe[c];
            ed = eo | x_first[c+1];
            tg = (x_tag[c] == "") ? "R10" : x_tag[c];
            if (eo) begin
                ri = 2 * x_pair[c];
                fi = ri + 1;
                rc = colf(x_base[c], ri);
                fc = colf(x_base[c], fi);
                bk = int'(x_bank[c]);
            end else begin
                ri = 0; fi = 0; rc = 0; fc = 0; bk = 0;
            end
            check(tg, "dq_oe", int'(dq_oe), int'(eo));
            check("R4", "dqs_oe", int'(dqs_oe), int'(ed));
            check("R2", "beat index", int'({rise_idx, fall_idx}), (ri << 2) | fi);
            check("R3", "beat column", (int'(rise_col) << 9) | int'(fall_col), (rc << 9) | fc);
            check(tg, "burst_bank", int'(burst_bank), bk);
            check("R9", "illegal_cmd", int'(illegal_cmd), int'(x_ill[c]));
        end
    end

    initial begin : watchdog
        #(5.0 * 100000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired at clock %0d", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stimulus
        // R10: reset state observed for a few clocks.
        @(negedge clk);
        mon_on = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        nops(2);

        // R1, R2, R3: plain read, column low bits 01.
        issue(C_READ, 2'b01, 9'h005, "R1");
        nops(6);
        // R3: wrap inside the group of four.
        issue(C_READ, 2'b10, 9'h0FF, "R3");
        nops(6);

        // R5: read one clock after a read, then three reads in a row.
        issue(C_READ, 2'b00, 9'h020, "R5");
        issue(C_READ, 2'b11, 9'h042, "R5");
        nops(6);
        issue(C_READ, 2'b01, 9'h100, "R5");
        issue(C_READ, 2'b10, 9'h113, "R5");
        issue(C_READ, 2'b11, 9'h126, "R5");
        nops(6);

        // R6: stop one clock after read (one pair delivered).
        issue(C_READ, 2'b01, 9'h010, "R6");
        issue(C_STOP, 2'b01, 9'h000, "R6");
        nops(6);
        // R6: stop two clocks after read (whole burst already due).
        issue(C_READ, 2'b10, 9'h031, "R6");
        nops(1);
        issue(C_STOP, 2'b10, 9'h000, "R6");
        nops(6);

        // R7: stop with a different bank still stops; bank of read reported.
        issue(C_READ, 2'b10, 9'h0A2, "R7");
        issue(C_STOP, 2'b01, 9'h1FF, "R7");
        nops(6);

        // R8: stop on an idle bus, then stop followed at once by a read.
        issue(C_STOP, 2'b11, 9'h000, "R8");
        nops(5);
        issue(C_STOP, 2'b00, 9'h000, "R8");
        issue(C_READ, 2'b01, 9'h057, "R8");
        nops(6);

        // Restart and float together: read, stop, read.
        issue(C_READ, 2'b00, 9'h061, "R6");
        issue(C_STOP, 2'b00, 9'h000, "R6");
        nops(1);
        issue(C_READ, 2'b11, 9'h07E, "R5");
        nops(6);

        // R9: stop inside the write window while a read is in flight.
        issue(C_WRITE, 2'b00, 9'h000, "R9");
        issue(C_READ, 2'b10, 9'h0C4, "R9");
        issue(C_STOP, 2'b10, 9'h000, "R9");
        nops(6);
        // R9: last clock of the window, then first clock after it.
        issue(C_WRITE, 2'b00, 9'h000, "R9");
        nops(2);
        issue(C_STOP, 2'b00, 9'h000, "R9");
        nops(4);
        issue(C_WRITE, 2'b00, 9'h000, "R9");
        issue(C_READ, 2'b01, 9'h0E9, "R9");
        nops(2);
        issue(C_STOP, 2'b01, 9'h000, "R9");
        nops(8);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule